// File: doc/BRIEF.md
# Programmable AND-OR Logic Array with Ten Output Cells

This block is a cycle-accurate model of a small programmable logic device. Its core is an array of product terms. Each term is an AND over any choice of true or complemented signals, taken from eleven dedicated inputs and ten feedback lines. The terms are grouped into ten OR sums of unequal size, one sum per output cell. Each output cell chooses between a combinational path and a clocked path, and applies its own output inversion. Each cell's pin is enabled by a product term of its own. When that term is false, the pin is left to the outside world and its value is read back into the array.

The contents of the array are written one row at a time through a parallel configuration port, and only while a configuration-mode input is high. A row is either a product term, with one connection bit per array column, or the mode row, which holds the register-select bits and the inversion bits. Two more term rows are shared by all cells. One presets every register on the next clock edge. The other clears every register at once, without waiting for a clock.

Top module: `pal_array`

## Requirements
- R1: Array column 2k holds signal k and column 2k+1 holds its complement, where signals 0..10 are `ded_in` and signals 11..20 are the feedback lines of cells 0..9. A term row bit at 1 connects that column. A term is true when every connected column is 1, so a row with no connections is always true and a row that connects both columns of one signal is always false.
- R2: Cell i owns one enable row at address B(i), followed by S(i) sum rows. Here S(i) = 8 + 2*min(i, 9-i), which gives 8,10,12,14,16,16,14,12,10,8, and B(i) is the sum of (1+S(j)) over j<i. The cell's sum is the OR of its S(i) rows, and every one of those rows, the last included, contributes.
- R3: A cell in combinational mode drives `io_out[i]` with its sum, inverted when bit 10+i of the mode row (address 132) is 1.
- R4: A cell in registered mode (mode row bit i = 1) loads its sum into its register on each rising edge, and drives `io_out[i]` with the register value, inverted when mode row bit 10+i is 1.
- R5: The feedback line of a registered cell carries its register value. The feedback line of a combinational cell carries `io_in[i]`, the pin level: either the cell's own driven value or the external value when the pin is not enabled.
- R6: `io_oe[i]` equals the value of cell i's enable row. When it is 0, the pin is an input.
- R7: When the shared preset row (address 130) is true at a rising edge, all ten registers become 1.
- R8: While the shared clear row (address 131) is true, all ten registers are 0 at once, with no clock needed, and the clear takes priority over the preset.
- R9: Writes are taken only while `cfg_mode` is 1; a write with `cfg_mode` at 0 leaves the array unchanged. While `cfg_mode` is 1, every `io_oe` bit is 0 and the registers keep their values, neither preset nor clear acting on them.
- R10: Reset (`rst_n` low) clears all registers, sets every connection bit of every term row to 1, so that every term is false and every pin is disabled, and sets the mode row to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers and the configuration writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ded_in | input | 11 | Dedicated array inputs |
| io_in | input | 10 | Level seen on each bidirectional pin |
| io_out | output | 10 | Value driven by each output cell |
| io_oe | output | 10 | Per-pin drive enable |
| cfg_mode | input | 1 | Configuration mode: opens writes, disables pins, freezes registers |
| cfg_we | input | 1 | Row write strobe |
| cfg_addr | input | 8 | Row address (terms 0..131, mode row 132) |
| cfg_data | input | 42 | Row contents |

## Verification
The bench builds the block with its default sizes: eleven dedicated inputs and ten cells. This yields the full 8-to-16 spread of sum sizes, so the last row of the smallest and of the largest sums can both be aimed at. The 42-column rows leave room for chains in which one cell's pin feeds another cell's term through the pin-level path. They also allow a registered cell to feed itself, which makes it toggle. With the preset and clear rows tied to two random inputs, every mix of the two is reached, including both at once and a clear that arrives between clock edges.

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_DED = 11,
  parameter int N_MC = 10,
  parameter int SZ_MIN = 8,
  parameter int SZ_STEP = 2,
  parameter int AW = 8,
  localparam int NCOL = 2 * (N_DED + N_MC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DED-1:0]  ded_in,
  input  logic [N_MC-1:0]   io_in,
  output logic [N_MC-1:0]   io_out,
  output logic [N_MC-1:0]   io_oe,
  input  logic              cfg_mode,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [NCOL-1:0]   cfg_data
);
  function automatic int sum_sz(int i);
    int d = (i < N_MC - 1 - i) ? i : N_MC - 1 - i;
    return SZ_MIN + SZ_STEP * d;
  endfunction

  function automatic int row_base(int i);
    int b = 0;
    for (int j = 0; j < i; j++) b += 1 + sum_sz(j);
    return b;
  endfunction

  function automatic logic pt(input logic [NCOL-1:0] row, input logic [NCOL-1:0] l);
    return &(~row | l);
  endfunction

  localparam int NSIG = N_DED + N_MC;
  localparam int N_TERM = row_base(N_MC);
  localparam int PRE_ROW = N_TERM;
  localparam int CLR_ROW = N_TERM + 1;
  localparam logic [AW-1:0] MODE_A = AW'(N_TERM + 2);

  logic [NCOL-1:0] arr [N_TERM+2];
  logic [N_MC-1:0] m_reg, m_inv, q, sum, oe_t, fb;
  logic [NCOL-1:0] lits;
  logic pre_t, ar_g;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int r = 0; r < N_TERM + 2; r++) arr[r] <= '1;
      m_reg <= '0;
      m_inv <= '0;
    end else if (cfg_mode && cfg_we) begin
      if (cfg_addr == MODE_A) begin
        m_reg <= cfg_data[N_MC-1:0];
        m_inv <= cfg_data[2*N_MC-1:N_MC];
      end else if (cfg_addr < MODE_A) begin
        arr[cfg_addr] <= cfg_data;
      end
    end

  assign fb = (m_reg & q) | (~m_reg & io_in);

  for (genvar gs = 0; gs < NSIG; gs++) begin : g_lit
    if (gs < N_DED) begin : g_d
      assign lits[2*gs]   = ded_in[gs];
      assign lits[2*gs+1] = ~ded_in[gs];
    end else begin : g_f
      assign lits[2*gs]   = fb[gs-N_DED];
      assign lits[2*gs+1] = ~fb[gs-N_DED];
    end
  end

  for (genvar gi = 0; gi < N_MC; gi++) begin : g_mc
    localparam int B = row_base(gi);
    localparam int S = sum_sz(gi);
    logic [S-1:0] hits;
    for (genvar gk = 0; gk < S; gk++) begin : g_t
      assign hits[gk] = pt(arr[B+1+gk], lits);
    end
    assign sum[gi]  = |hits;
    assign oe_t[gi] = pt(arr[B], lits);
  end

  assign pre_t = pt(arr[PRE_ROW], lits);
  assign ar_g  = pt(arr[CLR_ROW], lits) & ~cfg_mode;

  always_ff @(posedge clk or negedge rst_n or posedge ar_g)
    if (!rst_n)         q <= '0;
    else if (ar_g)      q <= '0;
    else if (!cfg_mode) q <= pre_t ? '1 : sum;

  assign io_out = ((m_reg & q) | (~m_reg & sum)) ^ m_inv;
  assign io_oe  = cfg_mode ? '0 : oe_t;
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
  parameter int N_MC = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_mode,
  input logic [N_MC-1:0] q,
  input logic            pre_t,
  input logic            ar_g,
  input logic [N_MC-1:0] io_oe
);
  a_r9_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> io_oe == '0);

  a_r9_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && $past(cfg_mode)) |-> q == $past(q));

  a_r8_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ar_g |-> q == '0);

  a_r7_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && pre_t && !ar_g) |=> (q == '1 || ar_g));
endmodule

bind pal_array pal_array_chk #(.N_MC(N_MC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .q(q),
  .pre_t(pre_t), .ar_g(ar_g), .io_oe(io_oe)
);

// File: tb/pal_array_tb_top.sv
`timescale 1ns/1ps
module pal_array_tb_top;
  localparam int ND = 11, NM = 10, NC = 42;
  localparam int PRE = 130, CLR = 131, MODE = 132;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_mode, cfg_we;
  logic [ND-1:0] ded_in;
  logic [NM-1:0] io_in, io_out, io_oe, ext;
  logic [7:0] cfg_addr;
  logic [NC-1:0] cfg_data;

  assign io_in = (io_oe & io_out) | (~io_oe & ext);

  pal_array dut_i (
    .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int errs = 0, checks = 0;

  logic [NC-1:0] mrow [132];
  logic [NM-1:0] mreg, minv, mq, m_out, m_oe, m_sum;
  logic m_pre, m_ar;

  function automatic int sz(int i);
    return 8 + 2 * ((i < 9 - i) ? i : 9 - i);
  endfunction
  function automatic int base(int i);
    int b = 0;
    for (int j = 0; j < i; j++) b += 1 + sz(j);
    return b;
  endfunction
  function automatic logic [NC-1:0] lit(int s, bit neg);
    logic [NC-1:0] v = '0;
    v[2*s + int'(neg)] = 1'b1;
    return v;
  endfunction
  function automatic logic term(logic [NC-1:0] row, logic [NC-1:0] l);
    for (int k = 0; k < NC; k++) if (row[k] && !l[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic eval();
    logic [NC-1:0] l;
    logic [NM-1:0] pads, fbv;
    repeat (6) begin
      pads = (m_oe & m_out) | (~m_oe & ext);
      for (int j = 0; j < NM; j++) fbv[j] = mreg[j] ? mq[j] : pads[j];
      for (int s = 0; s < ND + NM; s++) begin
        logic v = (s < ND) ? ded_in[s] : fbv[s-ND];
        l[2*s] = v;
        l[2*s+1] = ~v;
      end
      for (int i = 0; i < NM; i++) begin
        m_oe[i] = cfg_mode ? 1'b0 : term(mrow[base(i)], l);
        m_sum[i] = 1'b0;
        for (int k = 0; k < sz(i); k++) m_sum[i] |= term(mrow[base(i)+1+k], l);
        m_out[i] = (mreg[i] ? mq[i] : m_sum[i]) ^ minv[i];
      end
      m_pre = term(mrow[PRE], l);
      m_ar = term(mrow[CLR], l) && !cfg_mode;
      if (m_ar) mq = '0;
    end
  endtask

  task automatic cyc(bit cm, bit we, int a, logic [NC-1:0] d, string tag);
    @(negedge clk);
    ded_in = ND'($urandom);
    ext = NM'($urandom);
    cfg_mode = cm;
    cfg_we = we;
    cfg_addr = 8'(a);
    cfg_data = d;
    #1;
    eval();
    checks++;
    if (io_out !== m_out || io_oe !== m_oe) begin
      errs++;
      $display("FAIL %s: io_out=%b io_oe=%b expected io_out=%b io_oe=%b",
               tag, io_out, io_oe, m_out, m_oe);
    end
    @(posedge clk);
    if (!cm) mq = m_ar ? '0 : (m_pre ? '1 : m_sum);
    if (cm && we) begin
      if (a == MODE) begin
        mreg = d[NM-1:0];
        minv = d[2*NM-1:NM];
      end else if (a < MODE) mrow[a] = d;
    end
  endtask

  task automatic wr(int a, logic [NC-1:0] d);
    cyc(1'b1, 1'b1, a, d, "R9 write");
  endtask

  task automatic run(int n, string tag);
    for (int c = 0; c < n; c++) cyc(1'b0, 1'b0, 0, '0, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_mode = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    ded_in = '0; ext = '0;
    for (int r = 0; r < 132; r++) mrow[r] = '1;
    mreg = '0; minv = '0; mq = '0; m_out = '0; m_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (io_oe !== '0) begin
      errs++;
      $display("FAIL R10: io_oe=%b expected %b", io_oe, 10'b0);
    end
    checks++;
    if (io_out !== '0) begin
      errs++;
      $display("FAIL R10: io_out=%b expected %b", io_out, 10'b0);
    end
    run(20, "R10 blank array");

    // R1 R2 R3: single terms, last rows of small and large sums, inversion, contradiction
    wr(base(0), '0);
    wr(base(0) + 1, lit(0, 0) | lit(1, 1));
    wr(base(0) + 8, lit(2, 0) | lit(3, 0));
    wr(base(4), '0);
    wr(base(4) + 16, lit(4, 0));
    wr(base(9), '0);
    wr(base(9) + 8, lit(10, 1));
    wr(base(5), '0);
    wr(base(5) + 1, lit(5, 0));
    wr(base(6), '0);
    wr(base(6) + 1, lit(0, 0) | lit(0, 1));
    wr(MODE, NC'(1) << 15);
    run(150, "R1 R2 R3 sums");

    // R4 R5: registered self-toggle and registered inverted cell
    wr(MODE, (NC'(1) << 1) | (NC'(1) << 7) | (NC'(1) << 15) | (NC'(1) << 17));
    wr(base(1), '0);
    wr(base(1) + 1, lit(12, 1));
    wr(base(7), '0);
    wr(base(7) + 1, lit(7, 0));
    run(120, "R4 R5 registered");

    // R5 R6: enable from input, pin level fed to another cell
    wr(base(2), lit(8, 0));
    wr(base(2) + 1, lit(9, 0));
    wr(base(3), '0);
    wr(base(3) + 1, lit(13, 0));
    run(150, "R5 R6 pin enable");

    // R7 R8: shared preset and clear terms
    wr(PRE, lit(5, 0));
    wr(CLR, lit(6, 0));
    run(200, "R7 R8 preset clear");

    // R9: configuration mode holds state and releases pins; stray write ignored
    for (int c = 0; c < 20; c++) cyc(1'b1, 1'b0, 0, '0, "R9 cfg hold");
    run(10, "R9 after hold");
    cyc(1'b0, 1'b1, base(0), '1, "R9 ignored write");
    run(30, "R9 ignored write");

    summary();
  end
endmodule